// File: doc/BRIEF.md
# Fractional-Correction Baud Rate Generator

This block turns a fast system clock into a stream of single-cycle clock-enable ticks for a serial front end. The tick period is an integer number of system clocks set by a count field. A 4-bit correction field adds a fraction of a clock in sixteenths. The fraction comes from a small phase accumulator: it adds the correction once per correction step and stretches one period by a single extra clock whenever it carries out. The long-run average period then lands exactly on the requested non-integer value.

Two modes share the same counter. In UART mode each tick is a 16x oversampling enable, and the fraction is applied once per bit, on the 16th tick. The average bit period is then `16*(count+1) + corr/16` clocks. In infrared mode the tick is the base-rate enable, and the fraction is applied on every tick, giving an average period of `count+1 + corr/16` clocks. A per-bit strobe marks every 16th tick. Software loads the two fields through a simple write port. Each write restarts the divider cleanly.

Top module: `frac_baud_gen`

## Requirements
- R1: Reset clears both fields to zero and drops `cfg_err`. With `en` low, `tick` and `bit_stb` stay low. With `en` high in UART mode and the reset values, a tick occurs on every clock.
- R2: In UART mode, the non-stretched tick interval is `count+1` clocks. Over any 16 consecutive bits the total is exactly `256*(count+1) + corr` clocks.
- R3: In infrared mode, every tick interval is `count+1` or `count+2` clocks. Over any 16 consecutive ticks the total is exactly `16*(count+1) + corr` clocks.
- R4: A write with `wr_sel`=0 loads the count from `wr_data[CNT_W-1:0]`. A write with `wr_sel`=1 loads the correction from `wr_data[7:4]`. All other data bits have no effect.
- R5: `bit_stb` is high only together with `tick`, on every 16th tick counted from a restart.
- R6: In infrared mode a count of zero raises `cfg_err`. While `cfg_err` is high no tick is produced. Loading a nonzero count clears `cfg_err` and ticks resume.
- R7: A write clears the divider, the tick-within-bit counter and the accumulator. The first tick after the write then arrives in the `count+1`-th cycle following the write edge.
- R8: While `en` is low no tick is produced and the generator is held cleared. After `en` rises, the first tick arrives in the `count+1`-th cycle, counting the cycle in which `en` is first seen high.
- R9: In UART mode only the 16th tick of a bit may be stretched. All other tick intervals are exactly `count+1` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the generator cleared |
| ir_mode | input | 1 | 0 = UART oversampling mode, 1 = infrared base-rate mode |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 1 | 0 = count field, 1 = correction field |
| wr_data | input | DATA_W | Write data |
| tick | output | 1 | Clock-enable strobe, one cycle wide |
| bit_stb | output | 1 | Per-bit strobe on every 16th tick |
| cfg_err | output | 1 | Illegal zero count in infrared mode |

## Verification
The bench measures total cycles across 16 bits or 16 ticks with the correction at zero, at mid values and at its maximum of 15. A dither that dropped or doubled a carry would be off by one or more clocks in that total. It also records the shortest and longest tick intervals. A UART-mode generator that stretched a tick other than the last one of a bit would show a long interval on a non-bit tick, even though its average looked correct. Cycle-exact first-tick checks after a write and after enable catch a divider that fails to restart or starts one clock late. The infrared zero-count case and the ignored low bits of the correction word catch a generator that keeps running on an illegal setting or decodes the wrong field.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

   // Selects which field a write lands in
   typedef enum logic {
      SEL_COUNT = 1'b0,
      SEL_CORR  = 1'b1
   } reg_sel_e;

   // Operating mode of the generator
   typedef enum logic {
      MODE_UART = 1'b0,
      MODE_IR   = 1'b1
   } gen_mode_e;

endpackage

// File: rtl/frac_baud_cfg.sv
module frac_baud_cfg
   import frac_baud_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 8,
   parameter int FRAC_W   = 4,
   parameter int CORR_LSB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count_q,
   output logic [FRAC_W-1:0] corr_q
);

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         corr_q  <= '0;
      end else if (wr_en) begin
         if (reg_sel_e'(wr_sel) == SEL_COUNT)
            count_q <= wr_data[CNT_W-1:0];
         else
            corr_q  <= wr_data[CORR_LSB +: FRAC_W];
      end
   end

endmodule

// File: rtl/frac_baud_acc.sv
module frac_baud_acc #(
   parameter int FRAC_W    = 4,
   parameter bit DITHER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [FRAC_W-1:0] corr,
   output logic              carry_next
);

   generate
      if (DITHER_EN) begin : g_accum
         logic [FRAC_W-1:0] acc_q;
         logic [FRAC_W:0]   sum;

         assign sum        = {1'b0, acc_q} + {1'b0, corr};
         assign carry_next = sum[FRAC_W];

         always_ff @(posedge clk) begin
            if (!rst_n || clear)
               acc_q <= '0;
            else if (step)
               acc_q <= sum[FRAC_W-1:0];
         end
      end else begin : g_plain
         logic unused_acc_in;
         assign unused_acc_in = ^{clk, rst_n, clear, step, corr};
         assign carry_next    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/frac_baud_div.sv
module frac_baud_div #(
   parameter int CNT_W    = 8,
   parameter int OVS_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [CNT_W-1:0] lim_base,
   input  logic             stretch,
   output logic             tick,
   output logic             last_sub,
   output logic             bit_stb
);

   localparam int LIM_W = CNT_W + 1;

   logic [LIM_W-1:0]    div_q;
   logic [LIM_W-1:0]    lim;
   logic [OVS_LOG2-1:0] sub_q;

   assign lim      = {1'b0, lim_base} + LIM_W'(stretch);
   assign tick     = run && (div_q == lim);
   assign last_sub = &sub_q;
   assign bit_stb  = tick && last_sub;

   always_ff @(posedge clk) begin
      if (!rst_n || clear || !run) begin
         div_q <= '0;
         sub_q <= '0;
      end else if (tick) begin
         div_q <= '0;
         sub_q <= sub_q + 1'b1;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import frac_baud_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 8,
   parameter int FRAC_W    = 4,
   parameter int CORR_LSB  = 4,
   parameter int OVS_LOG2  = 4,
   parameter bit DITHER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ir_mode,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tick,
   output logic              bit_stb,
   output logic              cfg_err
);

   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 1 and DATA_W");
      end
      if (FRAC_W < 1 || CORR_LSB + FRAC_W > DATA_W) begin : g_bad_frac
         $error("correction field must fit inside DATA_W");
      end
      if (OVS_LOG2 < 1) begin : g_bad_ovs
         $error("OVS_LOG2 must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]  count_q;
   logic [FRAC_W-1:0] corr_q;
   logic              run;
   logic              apply_frac;
   logic              carry_next;
   logic              last_sub;
   logic              stretch;

   frac_baud_cfg #(
      .DATA_W  (DATA_W),
      .CNT_W   (CNT_W),
      .FRAC_W  (FRAC_W),
      .CORR_LSB(CORR_LSB)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .count_q(count_q),
      .corr_q (corr_q)
   );

   // Infrared mode cannot run with a zero count
   assign cfg_err = (gen_mode_e'(ir_mode) == MODE_IR) && (count_q == '0);
   assign run     = en && !cfg_err;

   // The fraction is applied per tick in infrared mode, per bit in UART mode
   assign apply_frac = (gen_mode_e'(ir_mode) == MODE_IR) || last_sub;
   assign stretch    = carry_next && apply_frac;

   frac_baud_acc #(
      .FRAC_W   (FRAC_W),
      .DITHER_EN(DITHER_EN)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (wr_en || !run),
      .step      (tick && apply_frac),
      .corr      (corr_q),
      .carry_next(carry_next)
   );

   frac_baud_div #(
      .CNT_W   (CNT_W),
      .OVS_LOG2(OVS_LOG2)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (wr_en),
      .run     (run),
      .lim_base(count_q),
      .stretch (stretch),
      .tick    (tick),
      .last_sub(last_sub),
      .bit_stb (bit_stb)
   );

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic ir_mode,
   input logic tick,
   input logic bit_stb,
   input logic cfg_err
);

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !tick);

   p_err_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !tick);

   p_bit_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> tick);

   p_ir_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_mode && tick) |=> (!tick || !ir_mode));

   p_err_only_ir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_mode |-> !cfg_err);

endmodule

bind frac_baud_gen frac_baud_chk u_chk (.*);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        ir_mode = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        tick;
   logic        bit_stb;
   logic        cfg_err;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   frac_baud_gen uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .ir_mode(ir_mode),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .tick   (tick),
      .bit_stb(bit_stb),
      .cfg_err(cfg_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Measures n events (bit strobes or ticks) after syncing to one
   task automatic span(input int n, input bit use_bit, output int cyc, output int nt,
                       output int minv, output int maxv, output int maxplain);
      int seen = 0;
      int last = 0;
      int guard = 0;
      cyc = 0; nt = 0; minv = 1 << 30; maxv = 0; maxplain = 0;
      @(negedge clk);
      while (!(use_bit ? bit_stb : tick) && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      while (seen < n && cyc < 100000) begin
         @(negedge clk);
         cyc++;
         if (tick) begin
            int iv = cyc - last;
            last = cyc;
            nt++;
            if (iv < minv) minv = iv;
            if (iv > maxv) maxv = iv;
            if (!bit_stb && iv > maxplain) maxplain = iv;
         end
         if (use_bit ? bit_stb : tick) seen++;
      end
   endtask

   task automatic t_reset();
      chk("R1 tick low after reset", int'(tick), 0);
      chk("R1 bit_stb low after reset", int'(bit_stb), 0);
      chk("R1 cfg_err low after reset", int'(cfg_err), 0);
      en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1 zero count ticks every clock", int'(tick), 1);
      @(negedge clk);
      chk("R1 zero count ticks every clock next", int'(tick), 1);
   endtask

   task automatic t_uart_frac();
      int cyc, nt, mn, mx, mp;
      ir_mode = 1'b0;
      wr(1'b0, 16'd3);
      wr(1'b1, 16'h0050);
      span(16, 1'b1, cyc, nt, mn, mx, mp);
      chk("R2 uart 16 bits count3 corr5", cyc, 1029);
      chk("R5 ticks per 16 bits", nt, 256);
      chk("R9 uart min interval", mn, 4);
      chk("R9 uart plain tick interval", mp, 4);
      chk("R2 uart stretched interval", mx, 5);
   endtask

   task automatic t_uart_full();
      int cyc, nt, mn, mx, mp;
      ir_mode = 1'b0;
      wr(1'b0, 16'd0);
      wr(1'b1, 16'h00F0);
      span(16, 1'b1, cyc, nt, mn, mx, mp);
      chk("R2 uart 16 bits count0 corr15", cyc, 271);
      chk("R9 uart plain interval count0", mp, 1);
      chk("R2 uart stretched interval count0", mx, 2);
   endtask

   task automatic t_ir_frac();
      int cyc, nt, mn, mx, mp;
      ir_mode = 1'b1;
      wr(1'b0, 16'd4);
      wr(1'b1, 16'h00B0);
      span(16, 1'b0, cyc, nt, mn, mx, mp);
      chk("R3 ir 16 ticks count4 corr11", cyc, 91);
      chk("R3 ir min interval", mn, 5);
      chk("R3 ir max interval", mx, 6);
      span(16, 1'b1, cyc, nt, mn, mx, mp);
      chk("R5 ir ticks per 16 bits", nt, 256);
      chk("R5 ir cycles per 16 bits", cyc, 16 * 91);
   endtask

   task automatic t_field();
      int cyc, nt, mn, mx, mp;
      ir_mode = 1'b1;
      wr(1'b0, 16'hFF04);
      wr(1'b1, 16'hF00F);
      span(16, 1'b0, cyc, nt, mn, mx, mp);
      chk("R4 low and high bits ignored total", cyc, 80);
      chk("R4 low bits ignored max interval", mx, 5);
      wr(1'b1, 16'h00A7);
      span(16, 1'b0, cyc, nt, mn, mx, mp);
      chk("R4 field bits 7:4 used", cyc, 90);
   endtask

   task automatic t_restart();
      ir_mode = 1'b1;
      wr(1'b1, 16'h0000);
      wr(1'b0, 16'd4);
      repeat (7) @(negedge clk);
      wr(1'b0, 16'd4);
      for (int k = 1; k <= 5; k++) begin
         if (k > 1) @(negedge clk);
         chk($sformatf("R7 ir restart cycle %0d", k), int'(tick), (k == 5) ? 1 : 0);
      end
      ir_mode = 1'b0;
      wr(1'b0, 16'd0);
      for (int k = 1; k <= 16; k++) begin
         if (k > 1) @(negedge clk);
         chk($sformatf("R5 bit strobe alignment cycle %0d", k), int'(bit_stb), (k == 16) ? 1 : 0);
      end
   endtask

   task automatic t_enable();
      int seen_ticks = 0;
      ir_mode = 1'b1;
      wr(1'b0, 16'd4);
      @(negedge clk);
      en = 1'b0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (tick) seen_ticks++;
      end
      chk("R8 no ticks while disabled", seen_ticks, 0);
      @(negedge clk);
      en = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         chk($sformatf("R8 first tick after enable step %0d", k), int'(tick), (k == 4) ? 1 : 0);
      end
   endtask

   task automatic t_err();
      int seen_ticks = 0;
      int cyc, nt, mn, mx, mp;
      ir_mode = 1'b1;
      wr(1'b0, 16'd0);
      chk("R6 zero ir count flags error", int'(cfg_err), 1);
      for (int k = 0; k < 50; k++) begin
         @(negedge clk);
         if (tick) seen_ticks++;
      end
      chk("R6 no ticks with error", seen_ticks, 0);
      wr(1'b0, 16'd2);
      chk("R6 error cleared by nonzero count", int'(cfg_err), 0);
      span(8, 1'b0, cyc, nt, mn, mx, mp);
      chk("R6 ticks resume total", cyc, 24);
      chk("R6 ticks resume interval", mx, 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_uart_frac();
      t_uart_full();
      t_ir_frac();
      t_field();
      t_restart();
      t_enable();
      t_err();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule